// File: doc/BRIEF.md
# Montgomery Final Add-Subtract Stage

This block finishes a Montgomery multiplication once the two wide products are available. It reads the double-length product AB (or, in reduce-only mode, a double-length input A taken as AB unchanged) together with the double-length product QN. It walks the 2*len word positions once, least significant word first, and forms two running results in each step: the sum S = AB + QN, and SN = S minus the modulus shifted up by len words. The sum uses a 1-bit carry chain and the difference uses a 1-bit borrow chain, so no separate comparison pass is needed.

Only the upper len words of S and of SN are kept, in two small word buffers. When the pass is over, the final carry and borrow decide which buffer holds the reduced value. That buffer is then streamed out through a word-write port. Operand words come from outside memories through a read-index port, and the data arrives one clock after the index. A start pulse launches the operation. A one-cycle done pulse closes it.

Top module: `mont_final_addsub`

## Requirements
- R1: While reset is high, and in the cycle after it is released, busy, done, rd_en and wr_en are all 0.
- R2: A start pulse seen while idle latches len (1 to MAXLEN) and the mode. The block then raises rd_en for exactly 2*len consecutive cycles, with rd_idx counting 0, 1, …, 2*len-1. The operand words for a given index are expected on the word inputs in the cycle after that index is presented.
- R3: The carry and the borrow are both cleared when an operation starts. A carry or borrow left over from the previous operation has no effect on the next result.
- R4: The subtrahend word for index i is 0 when i < len. Otherwise it is the modulus word at n_idx, and n_idx equals rd_idx - len whenever rd_en is high and rd_idx >= len.
- R5: With reduce_only = 1, a_word replaces ab_word as the AB operand, and ab_word is ignored.
- R6: The sum is selected, with took_sum = 1, exactly when the full sum S (including its carry) is below N·2^(len·W). This is the case where the final borrow is 1 and the final carry is 0. When S equals N·2^(len·W), the difference is selected.
- R7: The result consists of exactly len writes, with wr_addr running 0 to len-1. wr_data at address k is word len+k of the selected value (S, or S - N·2^(len·W) taken modulo 2^(2·len·W)).
- R8: done is a single-cycle pulse in the cycle after the last result write. busy falls in that same cycle.
- R9: A start pulse while busy is ignored. The running operation keeps its len and mode and finishes unchanged.
- R10: When the sum overflows 2·len words, the difference is selected, even if the 2·len-word subtraction also borrows in that same final step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, honoured only while idle |
| reduce_only | input | 1 | 1: use a_word as AB |
| len | input | LW | Operand length in words, 1..MAXLEN |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| took_sum | output | 1 | 1 when the result came from S |
| rd_en | output | 1 | Operand read request |
| rd_idx | output | IW | Word index for AB, A and QN |
| n_idx | output | AW | Word index for the modulus |
| ab_word | input | W | AB word, one cycle after the request |
| a_word | input | W | A word for reduce-only mode |
| qn_word | input | W | QN word |
| n_word | input | W | Modulus word |
| wr_en | output | 1 | Result word write strobe |
| wr_addr | output | AW | Result word index |
| wr_data | output | W | Result word |

## Verification
The carry out of the sum and the borrow out of the difference are both settled by the same final word step. The selection rule therefore has to combine them correctly when both are set at once. The bench provokes this with an AB of all-ones words plus a QN holding one unit in its upper half. The sum overflows, while its low 2·len words fall below the shifted modulus, so both chains end at 1. The result is judged against a wide reference computed in the bench: the expected result is the difference, and took_sum must read 0. The tie case, where S equals the shifted modulus exactly, and the stale-carry case surround this corner from either side.

// File: rtl/mfa_pkg.sv
package mfa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_FLUSH,
    ST_PICK,
    ST_EMIT,
    ST_TAIL
  } mfa_state_t;
endpackage

// File: rtl/mfa_chain.sv
module mfa_chain #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] add_a,
  input  logic [W-1:0] add_b,
  input  logic [W-1:0] sub_n,
  output logic [W-1:0] sum_w,
  output logic [W-1:0] diff_w,
  output logic         carry,
  output logic         borrow
);
  logic [W:0] sum_x;
  logic [W:0] diff_x;

  always_comb begin
    sum_x  = {1'b0, add_a} + {1'b0, add_b} + {{W{1'b0}}, carry};
    diff_x = {1'b0, sum_x[W-1:0]} - {1'b0, sub_n} - {{W{1'b0}}, borrow};
    sum_w  = sum_x[W-1:0];
    diff_w = diff_x[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      carry  <= 1'b0;
      borrow <= 1'b0;
    end else if (step) begin
      carry  <= sum_x[W];
      borrow <= diff_x[W];
    end
  end

  assert_chain_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (clr && !step) |=> (carry == 1'b0 && borrow == 1'b0));
endmodule

// File: rtl/mfa_wordbuf.sv
module mfa_wordbuf #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mont_final_addsub.sv
module mont_final_addsub
  import mfa_pkg::*;
#(
  parameter int W       = 16,
  parameter int MAXLEN  = 8,
  localparam int IW     = $clog2(2 * MAXLEN),
  localparam int AW     = (MAXLEN > 1) ? $clog2(MAXLEN) : 1,
  localparam int LW     = $clog2(MAXLEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          reduce_only,
  input  logic [LW-1:0] len,
  output logic          busy,
  output logic          done,
  output logic          took_sum,
  output logic          rd_en,
  output logic [IW-1:0] rd_idx,
  output logic [AW-1:0] n_idx,
  input  logic [W-1:0]  ab_word,
  input  logic [W-1:0]  a_word,
  input  logic [W-1:0]  qn_word,
  input  logic [W-1:0]  n_word,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [W-1:0]  wr_data
);
  mfa_state_t    state;
  logic [LW-1:0] len_q;
  logic          red_q;
  logic [IW-1:0] rd_cnt;
  logic          pv;
  logic [IW-1:0] pidx;
  logic [AW-1:0] ocnt;
  logic          ov;
  logic [AW-1:0] oaddr1;
  logic          accept;

  logic [IW-1:0] len_x;
  logic [LW:0]   two_len_m1;
  logic [IW-1:0] last_idx;
  logic [AW-1:0] last_out;
  logic          p_hi;
  logic [W-1:0]  op_a;
  logic [W-1:0]  op_n;
  logic [W-1:0]  sum_w, diff_w;
  logic          carry, borrow;
  logic [W-1:0]  s_q, sn_q;

  always_comb begin
    len_x      = IW'(len_q);
    two_len_m1 = {len_q, 1'b0} - (LW+1)'(1);
    last_idx   = IW'(two_len_m1);
    last_out   = AW'(len_q - LW'(1));
    accept     = start && (state == ST_IDLE);
    busy       = (state != ST_IDLE);
    rd_en      = (state == ST_READ);
    rd_idx     = rd_cnt;
    n_idx      = (rd_cnt >= len_x) ? AW'(rd_cnt - len_x) : '0;
    p_hi       = (pidx >= len_x);
    op_a       = red_q ? a_word : ab_word;
    op_n       = p_hi ? n_word : '0;
  end

  mfa_chain #(.W(W)) u_chain (
    .clk(clk), .rst(rst), .clr(accept), .step(pv),
    .add_a(op_a), .add_b(qn_word), .sub_n(op_n),
    .sum_w(sum_w), .diff_w(diff_w), .carry(carry), .borrow(borrow)
  );

  mfa_wordbuf #(.W(W), .DEPTH(MAXLEN)) u_sbuf (
    .clk(clk), .we(pv && p_hi), .waddr(AW'(pidx - len_x)), .wdata(sum_w),
    .re(state == ST_EMIT), .raddr(ocnt), .rdata(s_q)
  );

  mfa_wordbuf #(.W(W), .DEPTH(MAXLEN)) u_snbuf (
    .clk(clk), .we(pv && p_hi), .waddr(AW'(pidx - len_x)), .wdata(diff_w),
    .re(state == ST_EMIT), .raddr(ocnt), .rdata(sn_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      len_q    <= LW'(1);
      red_q    <= 1'b0;
      rd_cnt   <= '0;
      pv       <= 1'b0;
      pidx     <= '0;
      ocnt     <= '0;
      ov       <= 1'b0;
      oaddr1   <= '0;
      took_sum <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      done     <= 1'b0;
    end else begin
      pv     <= (state == ST_READ);
      pidx   <= rd_cnt;
      ov     <= (state == ST_EMIT);
      oaddr1 <= ocnt;
      wr_en  <= ov;
      wr_addr <= oaddr1;
      wr_data <= took_sum ? s_q : sn_q;
      done   <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          len_q  <= len;
          red_q  <= reduce_only;
          rd_cnt <= '0;
          state  <= ST_READ;
        end
        ST_READ: begin
          rd_cnt <= rd_cnt + IW'(1);
          if (rd_cnt == last_idx) state <= ST_FLUSH;
        end
        ST_FLUSH: state <= ST_PICK;
        ST_PICK: begin
          took_sum <= borrow && !carry;
          ocnt     <= '0;
          state    <= ST_EMIT;
        end
        ST_EMIT: begin
          ocnt <= ocnt + AW'(1);
          if (ocnt == last_out) state <= ST_TAIL;
        end
        ST_TAIL: if (wr_en && wr_addr == last_out) begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_read_range_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> ((LW+1)'(rd_idx) < {len_q, 1'b0}));
  assert_write_range_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (LW'(wr_addr) < len_q));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_follows_write_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(wr_en));
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(len_q) && $stable(red_q)));
endmodule

// File: tb/mont_final_addsub_tb.sv
module mont_final_addsub_tb;
  localparam int W      = 16;
  localparam int MAXLEN = 8;
  localparam int IW     = $clog2(2 * MAXLEN);
  localparam int AW     = $clog2(MAXLEN);
  localparam int LW     = $clog2(MAXLEN + 1);
  localparam int BW     = 2 * MAXLEN * W + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic reduce_only = 1'b0;
  logic [LW-1:0] len = LW'(1);
  logic busy, done, took_sum, rd_en, wr_en;
  logic [IW-1:0] rd_idx;
  logic [AW-1:0] n_idx, wr_addr;
  logic [W-1:0] ab_word, a_word, qn_word, n_word, wr_data;

  logic [W-1:0] mAB [2*MAXLEN];
  logic [W-1:0] mA  [2*MAXLEN];
  logic [W-1:0] mQN [2*MAXLEN];
  logic [W-1:0] mN  [MAXLEN];
  logic [W-1:0] got [MAXLEN];

  int total = 0;
  int bad = 0;
  int nwr = 0;
  int exp_rd = 0;
  int cur_len = 1;
  bit finished = 0;

  always #10 clk = ~clk;

  mont_final_addsub #(.W(W), .MAXLEN(MAXLEN)) u_dut (
    .clk(clk), .rst(rst), .start(start), .reduce_only(reduce_only), .len(len),
    .busy(busy), .done(done), .took_sum(took_sum), .rd_en(rd_en), .rd_idx(rd_idx),
    .n_idx(n_idx), .ab_word(ab_word), .a_word(a_word), .qn_word(qn_word),
    .n_word(n_word), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(posedge clk) begin
    if (rd_en) begin
      ab_word <= mAB[rd_idx];
      a_word  <= mA[rd_idx];
      qn_word <= mQN[rd_idx];
      n_word  <= mN[n_idx];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && rd_en) begin
      chk(int'(rd_idx) == exp_rd, "R2", "read order", 64'(rd_idx), 64'(exp_rd));
      if (int'(rd_idx) >= cur_len)
        chk(int'(n_idx) == int'(rd_idx) - cur_len, "R4", "n_idx",
            64'(n_idx), 64'(int'(rd_idx) - cur_len));
      exp_rd++;
    end
    if (!rst && wr_en) begin
      got[wr_addr] = wr_data;
      nwr++;
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 2*MAXLEN; i++) begin
      mAB[i] = '0; mA[i] = '0; mQN[i] = '0;
    end
    for (int i = 0; i < MAXLEN; i++) mN[i] = '0;
  endtask

  task automatic run_op(input int ln, input bit red, input bit poke, input string req);
    int cyc;
    cur_len = ln; exp_rd = 0; nwr = 0;
    for (int i = 0; i < MAXLEN; i++) got[i] = 'x;
    @(negedge clk);
    len = LW'(ln); reduce_only = red; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      len = LW'(1); reduce_only = !red; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, req, "done seen (watchdog)", 64'(done), 64'(1));
    chk(busy == 1'b0, "R8", "busy low with done", 64'(busy), 64'(0));
    chk(exp_rd == 2*ln, "R2", "read count", 64'(exp_rd), 64'(2*ln));
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle", 64'(done), 64'(0));
  endtask

  task automatic check_res(input int ln, input bit red, input string req);
    logic [BW-1:0] abv, qnv, sv, nsh, sel;
    bit es;
    abv = '0; qnv = '0; nsh = '0;
    for (int i = 0; i < 2*ln; i++) begin
      abv[i*W +: W] = red ? mA[i] : mAB[i];
      qnv[i*W +: W] = mQN[i];
    end
    for (int i = 0; i < ln; i++) nsh[(ln+i)*W +: W] = mN[i];
    sv = abv + qnv;
    es = (sv < nsh);
    sel = es ? sv : (sv - nsh);
    chk(took_sum == es, req, "took_sum", 64'(took_sum), 64'(es));
    chk(nwr == ln, "R7", "write count", 64'(nwr), 64'(ln));
    for (int k = 0; k < ln; k++)
      chk(got[k] === sel[(ln+k)*W +: W], req, $sformatf("word %0d", k),
          64'(got[k]), 64'(sel[(ln+k)*W +: W]));
  endtask

  task automatic fill_rand(input int ln);
    clear_mem();
    for (int i = 0; i < 2*ln; i++) begin
      mAB[i] = W'($urandom); mA[i] = W'($urandom); mQN[i] = W'($urandom);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_en && !wr_en, "R1", "idle in reset",
        {60'd0, busy, done, rd_en, wr_en}, 64'(0));
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !rd_en && !wr_en, "R1", "idle after reset",
        {60'd0, busy, done, rd_en, wr_en}, 64'(0));
  endtask

  task automatic t_basic_diff();
    fill_rand(4);
    mAB[7] = mAB[7] | 16'h8000;
    for (int i = 0; i < 4; i++) mN[i] = W'($urandom) & 16'h00FF;
    run_op(4, 0, 0, "R6");
    check_res(4, 0, "R6");
  endtask

  task automatic t_pick_sum();
    fill_rand(4);
    for (int i = 4; i < 8; i++) begin
      mAB[i] = mAB[i] & 16'h3FFF; mQN[i] = mQN[i] & 16'h3FFF;
    end
    for (int i = 0; i < 4; i++) mN[i] = 16'hFFFF;
    run_op(4, 0, 0, "R6");
    check_res(4, 0, "R6");
    chk(took_sum == 1'b1, "R6", "sum chosen", 64'(took_sum), 64'(1));
  endtask

  task automatic t_tie();
    clear_mem();
    for (int i = 0; i < 3; i++) begin
      mN[i] = W'($urandom) | 16'h0001;
      mAB[3+i] = mN[i];
    end
    run_op(3, 0, 0, "R6");
    check_res(3, 0, "R6");
    chk(took_sum == 1'b0, "R6", "tie takes difference", 64'(took_sum), 64'(0));
  endtask

  task automatic t_carry_and_borrow();
    clear_mem();
    for (int i = 0; i < 8; i++) mAB[i] = 16'hFFFF;
    mQN[4] = 16'h0001;
    for (int i = 0; i < 4; i++) mN[i] = 16'h1234;
    run_op(4, 0, 0, "R10");
    check_res(4, 0, "R10");
    chk(took_sum == 1'b0, "R10", "overflow takes difference", 64'(took_sum), 64'(0));
  endtask

  task automatic t_reduce();
    fill_rand(4);
    for (int i = 0; i < 4; i++) mN[i] = W'($urandom);
    run_op(4, 1, 0, "R5");
    check_res(4, 1, "R5");
  endtask

  task automatic t_len_edges();
    fill_rand(1);
    mN[0] = W'($urandom);
    run_op(1, 0, 0, "R7");
    check_res(1, 0, "R7");
    fill_rand(MAXLEN);
    for (int i = 0; i < MAXLEN; i++) mN[i] = W'($urandom);
    run_op(MAXLEN, 0, 0, "R2");
    check_res(MAXLEN, 0, "R2");
  endtask

  task automatic t_busy_start();
    fill_rand(5);
    for (int i = 0; i < 5; i++) mN[i] = W'($urandom);
    run_op(5, 0, 1, "R9");
    check_res(5, 0, "R9");
  endtask

  task automatic t_stale();
    t_carry_and_borrow();
    clear_mem();
    mAB[0] = 16'hFFFF; mAB[1] = 16'hFFFF; mAB[2] = 16'h0005; mAB[3] = 16'h0006;
    mN[0] = 16'h0001;
    run_op(2, 0, 0, "R3");
    check_res(2, 0, "R3");
  endtask

  initial begin
    clear_mem();
    t_reset();
    t_basic_diff();
    t_pick_sum();
    t_tie();
    t_carry_and_borrow();
    t_reduce();
    t_len_edges();
    t_busy_start();
    t_stale();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog run did not end actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule